// File: doc/BRIEF.md
# Sequential Combination Lock Controller

This block is the clocked controller of a door lock that opens only after a stored combination of three values has been keyed in the right order. Values arrive on a 4-bit digit bus. A value counts only in a cycle where the single-cycle `new_i` strobe is high. Each accepted value is compared with the stored code value for the step the lock has reached. A match moves the lock one step forward, and the third match opens the door. Any mismatch sends the lock to a rejection state.

Both outcomes are terminal. An open door stays open, and a rejected entry stays rejected, until the synchronous `rst` input is raised. There is no automatic relock and no retry. The combination is fixed at build time through the `CODE` parameter. Code value k sits in bits [4k+3:4k], so the value for the first step is in the low nibble. A separate `error_o` status lets the surrounding logic tell a rejected entry apart from an entry that is only unfinished.

Top module: `seq_lock_ctrl`

## Requirements
- R1: When `rst` is high at a rising clock edge, the lock is closed after that edge (`door_open_o`=0, `error_o`=0) and is back at the first step. This holds even when `new_i` is high in the same cycle.
- R2: In a cycle where `new_i` is low, the value on `digit_i` has no effect: the lock's step and both outputs stay as they were.
- R3: Three strobes that carry CODE[3:0], CODE[7:4] and CODE[11:8], in that order and starting from reset, raise `door_open_o` in the cycle after the edge of the third strobe.
- R4: After only one or two correct strobes, `door_open_o` and `error_o` are both low.
- R5: A strobed value that differs from the code value for the current step (first, second or third) raises `error_o` after that edge and keeps the door closed.
- R6: Once `error_o` is high, it stays high and the door stays closed until reset. Later strobes have no effect, even strobes that carry the correct code values.
- R7: Once `door_open_o` is high, it stays high and `error_o` stays low until reset, whatever values are strobed afterwards.
- R8: `door_open_o` and `error_o` are never high at the same time.
- R9: A `new_i` held high for several consecutive cycles counts as one entry per cycle. Each of those cycles is compared against the next code value in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to the first step with the door closed |
| digit_i | input | 4 | Value being entered |
| new_i | input | 1 | Accept strobe for `digit_i`, already synchronous to `clk` |
| door_open_o | output | 1 | High while the lock is open |
| error_o | output | 1 | High while the lock is in the rejected state |

## Verification
The bench drives a wrong value at each of the three steps in turn. A controller that compared against the wrong nibble, or that forgot its step, would open or fail at the wrong point. It presents noisy digit values with the strobe low in the middle of an entry, which catches a design that samples the bus without the strobe. It strobes the correct combination after a rejection and arbitrary values after an open, which exposes a lock that retries or relocks on its own. It also asserts reset together with a strobe, which exposes reset losing priority. Finally, it holds the strobe high over several cycles, which exposes a controller that detects edges instead of counting one entry per cycle.

// File: rtl/seq_lock_pkg.sv
package seq_lock_pkg;

  localparam int NUM_DIGITS = 3;
  localparam int SEL_W      = $clog2(NUM_DIGITS);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_GOT1  = 3'd1,
    ST_GOT2  = 3'd2,
    ST_OPEN  = 3'd3,
    ST_ERROR = 3'd4
  } lock_state_t;

  // True while the lock is still collecting values
  function automatic logic in_progress(lock_state_t s);
    return (s == ST_IDLE) || (s == ST_GOT1) || (s == ST_GOT2);
  endfunction

  // Which code value the current state compares against
  function automatic logic [SEL_W-1:0] step_index(lock_state_t s);
    case (s)
      ST_GOT1: return SEL_W'(1);
      ST_GOT2: return SEL_W'(2);
      default: return SEL_W'(0);
    endcase
  endfunction

  // State reached after a matching value
  function automatic lock_state_t advance(lock_state_t s);
    case (s)
      ST_IDLE: return ST_GOT1;
      ST_GOT1: return ST_GOT2;
      ST_GOT2: return ST_OPEN;
      default: return s;
    endcase
  endfunction

endpackage

// File: rtl/lock_digit_cmp.sv
module lock_digit_cmp
  import seq_lock_pkg::*;
#(
  parameter int DIGIT_W = 4,
  parameter logic [NUM_DIGITS*DIGIT_W-1:0] CODE = '0
) (
  input  logic [DIGIT_W-1:0] digit_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               match_o
);

  logic [NUM_DIGITS-1:0] hit_w;

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_hit
    assign hit_w[k] = (digit_i == CODE[k*DIGIT_W +: DIGIT_W]);
  end

  always_comb begin
    match_o = 1'b0;
    for (int k = 0; k < NUM_DIGITS; k++) begin
      if (sel_i == SEL_W'(k)) match_o = hit_w[k];
    end
  end

endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import seq_lock_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              new_i,
  input  logic              match_i,
  output logic [SEL_W-1:0]  sel_o,
  output lock_state_t       state_o
);

  lock_state_t state_q, state_d;

  // Named events, brought out for the checks below
  logic accept_w, good_w, bad_w;

  assign accept_w = new_i && in_progress(state_q);
  assign good_w   = accept_w && match_i;
  assign bad_w    = accept_w && !match_i;
  assign sel_o    = step_index(state_q);
  assign state_o  = state_q;

  always_comb begin
    state_d = state_q;
    if (good_w)     state_d = advance(state_q);
    else if (bad_w) state_d = ST_ERROR;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  // R2
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !new_i |=> $stable(state_q));

  // R3
  third_match_opens_chk: assert property (@(posedge clk) disable iff (rst)
    (good_w && state_q == ST_GOT2) |=> (state_q == ST_OPEN));

  // R5
  mismatch_rejects_chk: assert property (@(posedge clk) disable iff (rst)
    bad_w |=> (state_q == ST_ERROR));

  // R9
  entry_per_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    good_w |=> (state_q != $past(state_q)));

endmodule

// File: rtl/lock_status.sv
module lock_status
  import seq_lock_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  lock_state_t state_i,
  output logic        door_open_o,
  output logic        error_o
);

  assign door_open_o = (state_i == ST_OPEN);
  assign error_o     = (state_i == ST_ERROR);

  // R6
  error_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    error_o |=> (error_o && !door_open_o));

  // R7
  open_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    door_open_o |=> (door_open_o && !error_o));

endmodule

// File: rtl/seq_lock_ctrl.sv
module seq_lock_ctrl
  import seq_lock_pkg::*;
#(
  parameter int DIGIT_W = 4,
  parameter logic [NUM_DIGITS*DIGIT_W-1:0] CODE = 12'h593
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DIGIT_W-1:0] digit_i,
  input  logic               new_i,
  output logic               door_open_o,
  output logic               error_o
);

  logic [SEL_W-1:0] sel_w;
  logic             match_w;
  lock_state_t      state_w;

  lock_digit_cmp #(.DIGIT_W(DIGIT_W), .CODE(CODE)) u_cmp (
    .digit_i (digit_i),
    .sel_i   (sel_w),
    .match_o (match_w)
  );

  lock_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .new_i   (new_i),
    .match_i (match_w),
    .sel_o   (sel_w),
    .state_o (state_w)
  );

  lock_status u_stat (
    .clk         (clk),
    .rst         (rst),
    .state_i     (state_w),
    .door_open_o (door_open_o),
    .error_o     (error_o)
  );

  // R8
  outputs_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(door_open_o && error_o));

endmodule

// File: tb/seq_lock_ctrl_bench.sv
module seq_lock_ctrl_bench;

  localparam logic [3:0] K0 = 4'd3;
  localparam logic [3:0] K1 = 4'd9;
  localparam logic [3:0] K2 = 4'd5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] digit_i = 4'd0;
  logic       new_i = 1'b0;
  logic       door_open_o, error_o;

  always #2 clk = ~clk;

  seq_lock_ctrl #(.DIGIT_W(4), .CODE({K2, K1, K0})) u_seq_lock_ctrl (
    .clk(clk), .rst(rst), .digit_i(digit_i), .new_i(new_i),
    .door_open_o(door_open_o), .error_o(error_o)
  );

  typedef struct {
    logic  door;
    logic  err;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  bit   done     = 0;

  // Bench's own model of the lock
  int m_step = 0;
  bit m_open = 0;
  bit m_err  = 0;

  function automatic logic [3:0] code_at(int i);
    case (i)
      0: return K0;
      1: return K1;
      default: return K2;
    endcase
  endfunction

  task automatic drive(bit r, bit n, logic [3:0] d, string tag);
    exp_t e;
    @(negedge clk);
    rst = r; new_i = n; digit_i = d;
    if (r) begin
      m_step = 0; m_open = 0; m_err = 0;
    end else if (n && !m_open && !m_err) begin
      if (d == code_at(m_step)) begin
        m_step++;
        if (m_step == 3) m_open = 1;
      end else begin
        m_err = 1;
      end
    end
    e.door = m_open; e.err = m_err; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compares after each rising edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        n_checks++;
        if (door_open_o !== e.door || error_o !== e.err) begin
          n_fails++;
          $display("FAIL %s: door/err actual %b%b expected %b%b",
                   e.tag, door_open_o, error_o, e.door, e.err);
        end
        n_checks++;
        if (door_open_o === 1'b1 && error_o === 1'b1) begin
          n_fails++;
          $display("FAIL R8: door/err actual 11 expected not both high");
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    // R1: reset wins over a strobe in the same cycle
    drive(1, 1, K0, "R1");
    drive(1, 0, 4'd0, "R1");
    // R4 and R2: partial entry with bus noise between strobes
    drive(0, 1, K0, "R4");
    drive(0, 0, 4'd7, "R2");
    drive(0, 0, 4'd15, "R2");
    drive(0, 1, K1, "R4");
    drive(0, 0, 4'd1, "R2");
    // R3: third correct value opens
    drive(0, 1, K2, "R3");
    drive(0, 0, 4'd0, "R3");
    // R7: open ignores further strobes
    drive(0, 1, 4'd12, "R7");
    drive(0, 1, K0, "R7");
    drive(0, 1, K1, "R7");
    // R1: reset while open and strobed
    drive(1, 1, K1, "R1");
    // R5 at first step, then R6 sticky despite the correct code
    drive(0, 1, 4'd8, "R5");
    drive(0, 1, K0, "R6");
    drive(0, 1, K1, "R6");
    drive(0, 1, K2, "R6");
    drive(0, 0, 4'd2, "R6");
    // R5 at second step
    drive(1, 0, 4'd0, "R1");
    drive(0, 1, K0, "R4");
    drive(0, 1, K0, "R5");
    drive(0, 0, 4'd0, "R6");
    // R5 at third step
    drive(1, 0, 4'd0, "R1");
    drive(0, 1, K0, "R4");
    drive(0, 1, K1, "R4");
    drive(0, 1, K1, "R5");
    // R9: strobe held two cycles with the first value, so the second is rejected
    drive(1, 0, 4'd0, "R1");
    drive(0, 1, K0, "R9");
    drive(0, 1, K0, "R9");
    // R9: strobe held three cycles with changing values opens the lock
    drive(1, 0, 4'd0, "R1");
    drive(0, 1, K0, "R9");
    drive(0, 1, K1, "R9");
    drive(0, 1, K2, "R9");
    drive(0, 0, 4'd0, "R7");
    // R2 from idle: bus noise without strobe keeps the lock closed
    drive(1, 0, 4'd0, "R1");
    drive(0, 0, K0, "R2");
    drive(0, 0, K1, "R2");
    drive(0, 1, K1, "R5");
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule